// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks one processor's reservation for a load-linked / store-conditional pair. A load-linked records the cache block it touched and arms a reservation. A store-conditional to that block is allowed to write only while the reservation is still armed. Anything that could break atomicity disarms the reservation: an interrupt, a context switch, or an invalidation of the reserved block caused by another agent's store. The result is a read-modify-write sequence that behaves atomically without locking the bus.

The core feeds the monitor its load-linked and store-conditional requests, together with the addresses. The coherence side feeds it the stream of invalidated addresses. One cycle after each store-conditional, the monitor reports whether it succeeded. It also raises the write enable that lets the store reach the cache.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is armed, and `sc_done`, `sc_ok` and `sc_wr_en` are 0.
- R2: A load-linked arms the reservation and remembers the block of `ll_addr`. A later store-conditional to the same block while armed gives `sc_done`=1, `sc_ok`=1 and `sc_wr_en`=1 one cycle after the request.
- R3: A store-conditional made while no reservation is armed, or to a block other than the reserved one, gives `sc_done`=1, `sc_ok`=0 and `sc_wr_en`=0 one cycle later.
- R4: A pulse on `irq_evt` or on `ctx_evt` disarms the reservation.
- R5: Addresses are compared per block, so the low `OFFSET_W` bits (6 by default, a 64-byte block) are ignored. An invalidation whose address lies in the reserved block disarms the reservation. An invalidation of any other block has no effect.
- R6: Every store-conditional disarms the reservation, whether it succeeds or fails.
- R7: If an invalidation of the reserved block, an interrupt or a context switch arrives in the same cycle as a store-conditional, the store-conditional fails.
- R8: A new load-linked replaces any earlier reservation. When a load-linked coincides with a disarming event or with a store-conditional, the store-conditional is judged on the old reservation, and the new reservation is the one left armed.
- R9: `sc_done` is 1 in exactly the cycle after each store-conditional request, and 0 in every other cycle. `sc_wr_en` is never 1 unless `sc_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Load-linked issued this cycle |
| ll_addr | input | ADDR_W | Load-linked address |
| sc_req | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | ADDR_W | Store-conditional address |
| inv_valid | input | 1 | Invalidation from another agent's store this cycle |
| inv_addr | input | ADDR_W | Invalidated address |
| irq_evt | input | 1 | Interrupt taken (one-cycle pulse) |
| ctx_evt | input | 1 | Context switch (one-cycle pulse) |
| sc_done | output | 1 | Store-conditional result is valid |
| sc_ok | output | 1 | Store-conditional succeeded (1) or failed (0) |
| sc_wr_en | output | 1 | Let the store-conditional write proceed |

## Verification
All three outputs are registered. A store-conditional presented in one cycle therefore has its `sc_done`, `sc_ok` and `sc_wr_en` in the next cycle. An event that disarms or re-arms the reservation shows up in the result of the next store-conditional issued on a later cycle. The bench drives each stimulus vector just after a falling edge, holds it for one cycle, and samples the outputs on the following falling edge. That is exactly one rising edge after the request, so each sample sees that request's result. Events that change only the reservation are checked through the store-conditional vector that follows them.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  localparam int unsigned MAX_ADDR_W = 64;

  typedef logic [MAX_ADDR_W-1:0] wide_addr_t;

  function automatic logic same_block(input wide_addr_t a, input wide_addr_t b,
                                      input int unsigned offset_w);
    return (a >> offset_w) == (b >> offset_w);
  endfunction

  function automatic wide_addr_t block_of(input wide_addr_t a, input int unsigned offset_w);
    return a >> offset_w;
  endfunction

endpackage

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 6,
  localparam int unsigned TAG_W   = ADDR_W - OFFSET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TAG_W-1:0] arm_tag,
  input  logic             disarm,
  output logic             armed,
  output logic [TAG_W-1:0] tag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tag   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      tag   <= arm_tag;
    end else if (disarm) begin
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/llsc_kill_detect.sv
module llsc_kill_detect
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 6,
  localparam int unsigned TAG_W   = ADDR_W - OFFSET_W
) (
  input  logic              armed,
  input  logic [TAG_W-1:0]  tag,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              irq_evt,
  input  logic              ctx_evt,
  input  logic              sc_req,
  output logic              inv_hit,
  output logic              async_kill,
  output logic              any_kill
);

  logic [ADDR_W-1:0] tag_as_addr;
  assign tag_as_addr = {tag, {OFFSET_W{1'b0}}};

  always_comb begin
    inv_hit    = inv_valid && armed &&
                 same_block(wide_addr_t'(inv_addr), wide_addr_t'(tag_as_addr), OFFSET_W);
    async_kill = inv_hit || irq_evt || ctx_evt;
    any_kill   = async_kill || sc_req;
  end

endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 6,
  localparam int unsigned TAG_W   = ADDR_W - OFFSET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              armed,
  input  logic [TAG_W-1:0]  tag,
  input  logic              async_kill,
  output logic              sc_grant,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              sc_wr_en
);

  logic [ADDR_W-1:0] tag_as_addr;
  logic              addr_match;

  assign tag_as_addr = {tag, {OFFSET_W{1'b0}}};

  always_comb begin
    addr_match = same_block(wide_addr_t'(sc_addr), wide_addr_t'(tag_as_addr), OFFSET_W);
    sc_grant   = sc_req && armed && addr_match && !async_kill;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_done  <= 1'b0;
      sc_ok    <= 1'b0;
      sc_wr_en <= 1'b0;
    end else begin
      sc_done  <= sc_req;
      sc_ok    <= sc_grant;
      sc_wr_en <= sc_grant;
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              irq_evt,
  input  logic              ctx_evt,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              sc_wr_en
);

  localparam int unsigned TAG_W = ADDR_W - OFFSET_W;

  logic             link_valid;
  logic [TAG_W-1:0] link_tag;
  logic             inv_hit;
  logic             async_kill;
  logic             any_kill;
  logic             sc_grant;

  llsc_link_reg #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (ll_req),
    .arm_tag (ll_addr[ADDR_W-1:OFFSET_W]),
    .disarm  (any_kill),
    .armed   (link_valid),
    .tag     (link_tag)
  );

  llsc_kill_detect #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) u_kill (
    .armed      (link_valid),
    .tag        (link_tag),
    .inv_valid  (inv_valid),
    .inv_addr   (inv_addr),
    .irq_evt    (irq_evt),
    .ctx_evt    (ctx_evt),
    .sc_req     (sc_req),
    .inv_hit    (inv_hit),
    .async_kill (async_kill),
    .any_kill   (any_kill)
  );

  llsc_sc_judge #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_req     (sc_req),
    .sc_addr    (sc_addr),
    .armed      (link_valid),
    .tag        (link_tag),
    .async_kill (async_kill),
    .sc_grant   (sc_grant),
    .sc_done    (sc_done),
    .sc_ok      (sc_ok),
    .sc_wr_en   (sc_wr_en)
  );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic ll_req,
  input logic sc_req,
  input logic irq_evt,
  input logic ctx_evt,
  input logic link_valid,
  input logic inv_hit,
  input logic sc_done,
  input logic sc_ok,
  input logic sc_wr_en
);

  // R9
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> sc_done);

  // R9
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_req |=> !sc_done);

  // R9
  wr_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr_en |-> (sc_ok && sc_done));

  // R7
  inv_beats_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && inv_hit) |=> !sc_ok);

  // R3
  unarmed_sc_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !link_valid) |=> !sc_ok);

  // R4
  event_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_evt || ctx_evt) && !ll_req) |=> !link_valid);

  // R6
  sc_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !ll_req) |=> !link_valid);

  // R8
  ll_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ll_req |=> link_valid);

endmodule

bind llsc_monitor llsc_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ll_req     (ll_req),
  .sc_req     (sc_req),
  .irq_evt    (irq_evt),
  .ctx_evt    (ctx_evt),
  .link_valid (link_valid),
  .inv_hit    (inv_hit),
  .sc_done    (sc_done),
  .sc_ok      (sc_ok),
  .sc_wr_en   (sc_wr_en)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;

  localparam int AW = 32;
  localparam logic [31:0] A  = 32'h0000_1000;
  localparam logic [31:0] A2 = 32'h0000_1038;
  localparam logic [31:0] AI = 32'h0000_1010;
  localparam logic [31:0] B  = 32'h0000_2000;
  localparam logic [31:0] Z  = 32'h0;

  typedef struct packed {
    logic [15:0] rq;
    logic        ll;
    logic [31:0] lla;
    logic        sc;
    logic [31:0] sca;
    logic        inv;
    logic [31:0] inva;
    logic        irq;
    logic        ctx;
    logic        ok;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [0:NV-1] = '{
    '{"R2", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R2", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b1},
    '{"R6", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R5", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R5", 1'b0, Z, 1'b1, A2, 1'b0, Z,  1'b0, 1'b0, 1'b1},
    '{"R3", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R3", 1'b0, Z, 1'b1, B,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R6", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R4", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R4", 1'b0, Z, 1'b0, Z,  1'b0, Z,  1'b1, 1'b0, 1'b0},
    '{"R4", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R4", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R4", 1'b0, Z, 1'b0, Z,  1'b0, Z,  1'b0, 1'b1, 1'b0},
    '{"R4", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R5", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R5", 1'b0, Z, 1'b0, Z,  1'b1, AI, 1'b0, 1'b0, 1'b0},
    '{"R5", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R5", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R5", 1'b0, Z, 1'b0, Z,  1'b1, B,  1'b0, 1'b0, 1'b0},
    '{"R5", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b1},
    '{"R7", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R7", 1'b0, Z, 1'b1, A,  1'b1, A,  1'b0, 1'b0, 1'b0},
    '{"R7", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R8", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R8", 1'b1, B, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R8", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R8", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R8", 1'b1, B, 1'b0, Z,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R8", 1'b0, Z, 1'b1, B,  1'b0, Z,  1'b0, 1'b0, 1'b1},
    '{"R8", 1'b1, A, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b0},
    '{"R8", 1'b0, Z, 1'b1, A,  1'b0, Z,  1'b0, 1'b0, 1'b1},
    '{"R8", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b1, 1'b0, 1'b0},
    '{"R8", 1'b0, Z, 1'b1, A2, 1'b0, Z,  1'b0, 1'b0, 1'b1},
    '{"R7", 1'b1, A, 1'b0, Z,  1'b0, Z,  1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_req = 1'b0, sc_req = 1'b0, inv_valid = 1'b0, irq_evt = 1'b0, ctx_evt = 1'b0;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, inv_addr = '0;
  logic sc_done, sc_ok, sc_wr_en;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .OFFSET_W(6)) u_llsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .ll_req(ll_req), .ll_addr(ll_addr),
    .sc_req(sc_req), .sc_addr(sc_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .irq_evt(irq_evt), .ctx_evt(ctx_evt),
    .sc_done(sc_done), .sc_ok(sc_ok), .sc_wr_en(sc_wr_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=5000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string rq, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%b exp=%b", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    ll_req = 0; sc_req = 0; inv_valid = 0; irq_evt = 0; ctx_evt = 0;
    ll_addr = '0; sc_addr = '0; inv_addr = '0;
  endtask

  task automatic apply(input string rq, input vec_t v);
    ll_req = v.ll; ll_addr = v.lla; sc_req = v.sc; sc_addr = v.sca;
    inv_valid = v.inv; inv_addr = v.inva; irq_evt = v.irq; ctx_evt = v.ctx;
    @(negedge clk);
    check(rq, "sc_done", sc_done, v.sc);
    check(rq, "sc_ok", sc_ok, v.sc & v.ok);
    check(rq, "sc_wr_en", sc_wr_en, v.sc & v.ok);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1", "sc_done", sc_done, 1'b0);
    check("R1", "sc_ok", sc_ok, 1'b0);
    check("R1", "sc_wr_en", sc_wr_en, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sc_done idle", sc_done, 1'b0);
    // R1 no reservation after reset: SC fails
    apply("R1", '{"R1", 1'b0, Z, 1'b1, A, 1'b0, Z, 1'b0, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply({8'(VEC[i].rq >> 8), 8'(VEC[i].rq)}, VEC[i]);
    end
    idle();
    @(negedge clk);
    // R9 no done without request
    check("R9", "sc_done quiet", sc_done, 1'b0);

    // R1 reset drops a reservation
    apply("R1", '{"R1", 1'b1, A, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0, 1'b0});
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply("R1", '{"R1", 1'b0, Z, 1'b1, A, 1'b0, Z, 1'b0, 1'b0, 1'b0});

    // R5 invalidation at last byte of the linked block
    apply("R5", '{"R5", 1'b1, A, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0, 1'b0});
    apply("R5", '{"R5", 1'b0, Z, 1'b0, Z, 1'b1, 32'h0000_103F, 1'b0, 1'b0, 1'b0});
    apply("R5", '{"R5", 1'b0, Z, 1'b1, A, 1'b0, Z, 1'b0, 1'b0, 1'b0});

    // R5 neighbouring block just past the boundary leaves link intact
    apply("R5", '{"R5", 1'b1, A, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0, 1'b0});
    apply("R5", '{"R5", 1'b0, Z, 1'b0, Z, 1'b1, 32'h0000_1040, 1'b0, 1'b0, 1'b0});
    apply("R5", '{"R5", 1'b0, Z, 1'b1, A, 1'b0, Z, 1'b0, 1'b0, 1'b1});

    // R7 interrupt in same cycle as SC
    apply("R7", '{"R7", 1'b1, A, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0, 1'b0});
    apply("R7", '{"R7", 1'b0, Z, 1'b1, A, 1'b0, Z, 1'b1, 1'b0, 1'b0});

    // R9 back-to-back SCs each give one done
    apply("R9", '{"R9", 1'b1, B, 1'b0, Z, 1'b0, Z, 1'b0, 1'b0, 1'b0});
    apply("R9", '{"R9", 1'b0, Z, 1'b1, B, 1'b0, Z, 1'b0, 1'b0, 1'b1});
    apply("R9", '{"R9", 1'b0, Z, 1'b1, B, 1'b0, Z, 1'b0, 1'b0, 1'b0});
    idle();
    @(negedge clk);
    check("R9", "sc_done after pair", sc_done, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule